// File: doc/BRIEF.md
# Multi-stream valid/ready synchronizer

This block is a purely combinational handshake node. It joins a set of source streams (which offer data with a valid) and a set of destination streams (which accept data with a ready) so that every participating stream transfers in one and the same clock cycle. It carries no data; the surrounding logic routes payload and uses the node's outputs to decide when words move.

Each stream has two qualifiers. A gate input must be high for the stream to take part in a transfer, and when it is low the whole node stalls. A bypass input removes the stream from the node entirely: nobody waits for it, it is never handshaken, and its gate is ignored. A node-wide enable stalls everything when low. The `fire` output is high in every cycle in which the joint transfer happens.

Top module: `stream_join_sync`

## Requirements
- R1: `fire` is high exactly when `en` is high and every non-bypassed source has valid and gate high and every non-bypassed destination has ready and gate high.
- R2: With `en` low, every `src_ready` bit, every `dst_valid` bit and `fire` are 0.
- R3: `src_ready[i]` is high exactly when `en`, `src_gate[i]` and not `src_bypass[i]` hold, every other non-bypassed source has valid and gate high, and every non-bypassed destination has ready and gate high; it never depends on `src_valid[i]`.
- R4: `dst_valid[j]` is high exactly when `en`, `dst_gate[j]` and not `dst_bypass[j]` hold, every non-bypassed source has valid and gate high, and every other non-bypassed destination has ready and gate high; it never depends on `dst_ready[j]`.
- R5: A low gate on any non-bypassed stream forces `fire`, all `src_ready` bits and all `dst_valid` bits to 0.
- R6: A bypassed stream always receives 0 on its `src_ready` or `dst_valid` bit, and its own valid or ready input has no effect on any output.
- R7: A bypassed stream whose gate is low does not block the other streams.
- R8: On every non-bypassed source, valid and ready are both high exactly in the cycles where `fire` is high, and likewise valid and ready on every non-bypassed destination.
- R9: With every stream bypassed and `en` high, `fire` is 1 and all `src_ready` and `dst_valid` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en | input | 1 | Node-wide enable |
| src_valid | input | N_SRC | Valid from each source stream |
| src_gate | input | N_SRC | Per-source participation gate |
| src_bypass | input | N_SRC | Per-source removal from the node |
| src_ready | output | N_SRC | Ready returned to each source |
| dst_ready | input | N_DST | Ready from each destination stream |
| dst_gate | input | N_DST | Per-destination participation gate |
| dst_bypass | input | N_DST | Per-destination removal from the node |
| dst_valid | output | N_DST | Valid driven to each destination |
| fire | output | 1 | High when the joint transfer occurs |

## Verification
The hardest situation to reach is a transfer with a mix of bypassed streams, some of them gated low, while all remaining streams happen to be valid, ready and gated high at once; uniform random inputs almost never line up that way. The stimulus biases valid, ready and gate toward high and bypass toward low, and adds directed cycles that bypass a gated-off stream, bypass every stream, and toggle a bypassed stream's own handshake input to show it changes nothing.

// File: rtl/stream_join_sync.sv
module stream_join_sync #(
  parameter int N_SRC = 3,
  parameter int N_DST = 2
) (
  input  logic             en,
  input  logic [N_SRC-1:0] src_valid,
  input  logic [N_SRC-1:0] src_gate,
  input  logic [N_SRC-1:0] src_bypass,
  output logic [N_SRC-1:0] src_ready,
  input  logic [N_DST-1:0] dst_ready,
  input  logic [N_DST-1:0] dst_gate,
  input  logic [N_DST-1:0] dst_bypass,
  output logic [N_DST-1:0] dst_valid,
  output logic             fire
);
  logic [N_SRC-1:0] src_ok;
  logic [N_DST-1:0] dst_ok;

  assign src_ok = src_bypass | (src_valid & src_gate);
  assign dst_ok = dst_bypass | (dst_ready & dst_gate);
  assign fire   = en & (&src_ok) & (&dst_ok);

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
    logic [N_SRC-1:0] peers;
    always_comb begin
      peers     = src_ok;
      peers[gi] = 1'b1;
    end
    assign src_ready[gi] = en & ~src_bypass[gi] & src_gate[gi] & (&peers) & (&dst_ok);
  end

  for (genvar gj = 0; gj < N_DST; gj++) begin : g_dst
    logic [N_DST-1:0] peers;
    always_comb begin
      peers     = dst_ok;
      peers[gj] = 1'b1;
    end
    assign dst_valid[gj] = en & ~dst_bypass[gj] & dst_gate[gj] & (&peers) & (&src_ok);
  end
endmodule

// File: rtl/stream_join_sync_chk.sv
module stream_join_sync_chk #(
  parameter int N_SRC = 3,
  parameter int N_DST = 2
) (
  input logic             en,
  input logic [N_SRC-1:0] src_valid,
  input logic [N_SRC-1:0] src_gate,
  input logic [N_SRC-1:0] src_bypass,
  input logic [N_SRC-1:0] src_ready,
  input logic [N_DST-1:0] dst_ready,
  input logic [N_DST-1:0] dst_gate,
  input logic [N_DST-1:0] dst_bypass,
  input logic [N_DST-1:0] dst_valid,
  input logic             fire
);
  always_comb begin
    assert_idle_when_off_R2: assert (en || (src_ready == '0 && dst_valid == '0 && !fire));
    for (int i = 0; i < N_SRC; i++) begin
      assert_src_beat_R8: assert ((src_valid[i] && src_ready[i]) == (fire && !src_bypass[i]));
      assert_src_bypass_R6: assert (!(src_bypass[i] && src_ready[i]));
      assert_src_present_R1: assert (!fire || src_bypass[i] || (src_valid[i] && src_gate[i]));
    end
    for (int j = 0; j < N_DST; j++) begin
      assert_dst_beat_R8: assert ((dst_valid[j] && dst_ready[j]) == (fire && !dst_bypass[j]));
      assert_dst_bypass_R6: assert (!(dst_bypass[j] && dst_valid[j]));
      assert_dst_present_R1: assert (!fire || dst_bypass[j] || (dst_ready[j] && dst_gate[j]));
    end
  end
endmodule

bind stream_join_sync stream_join_sync_chk #(.N_SRC(N_SRC), .N_DST(N_DST)) u_chk (.*);

// File: tb/test_stream_join_sync.sv
module test_stream_join_sync;
  localparam int NS = 3;
  localparam int ND = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          en;
  logic [NS-1:0] sv, sg, sb, sr;
  logic [ND-1:0] dr, dg, db, dv;
  logic          fire;

  int checks = 0;
  int fails  = 0;

  stream_join_sync #(.N_SRC(NS), .N_DST(ND)) i_stream_join_sync (
    .en(en), .src_valid(sv), .src_gate(sg), .src_bypass(sb), .src_ready(sr),
    .dst_ready(dr), .dst_gate(dg), .dst_bypass(db), .dst_valid(dv), .fire(fire)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model, evaluated on current inputs.
  task automatic compare(string tag);
    bit ok_s[NS];
    bit ok_d[ND];
    bit all_ok;
    logic [NS-1:0] e_sr;
    logic [ND-1:0] e_dv;
    logic [NS-1:0] hs_s, e_hs_s;
    logic [ND-1:0] hs_d, e_hs_d;
    all_ok = 1;
    for (int k = 0; k < NS; k++) begin
      ok_s[k] = sb[k] || (sv[k] && sg[k]);
      if (!ok_s[k]) all_ok = 0;
    end
    for (int k = 0; k < ND; k++) begin
      ok_d[k] = db[k] || (dr[k] && dg[k]);
      if (!ok_d[k]) all_ok = 0;
    end
    for (int i = 0; i < NS; i++) begin
      bit r;
      r = en && !sb[i] && sg[i];
      for (int k = 0; k < NS; k++) if (k != i && !ok_s[k]) r = 0;
      for (int k = 0; k < ND; k++) if (!ok_d[k]) r = 0;
      e_sr[i] = r;
    end
    for (int j = 0; j < ND; j++) begin
      bit r;
      r = en && !db[j] && dg[j];
      for (int k = 0; k < NS; k++) if (!ok_s[k]) r = 0;
      for (int k = 0; k < ND; k++) if (k != j && !ok_d[k]) r = 0;
      e_dv[j] = r;
    end
    for (int i = 0; i < NS; i++) e_hs_s[i] = en && all_ok && !sb[i];
    for (int j = 0; j < ND; j++) e_hs_d[j] = en && all_ok && !db[j];
    hs_s = sv & sr;
    hs_d = dr & dv;
    chk({"R1 fire ", tag}, 32'(fire), 32'(en && all_ok));
    chk({"R3 src_ready ", tag}, 32'(sr), 32'(e_sr));
    chk({"R4 dst_valid ", tag}, 32'(dv), 32'(e_dv));
    chk({"R8 src handshake ", tag}, 32'(hs_s), 32'(e_hs_s));
    chk({"R8 dst handshake ", tag}, 32'(hs_d), 32'(e_hs_d));
  endtask

  task automatic drive(logic e, logic [NS-1:0] v, g, b, logic [ND-1:0] r, dgi, dbi);
    @(negedge clk);
    en = e; sv = v; sg = g; sb = b; dr = r; dg = dgi; db = dbi;
    #1;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    en = 0; sv = '0; sg = '0; sb = '0; dr = '0; dg = '0; db = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset fire", 32'(fire), 0);
    chk("R2 reset src_ready", 32'(sr), 0);
    chk("R2 reset dst_valid", 32'(dv), 0);
    rst_n = 1'b1;

    // R1: everything present
    drive(1, '1, '1, '0, '1, '1, '0);
    chk("R1 full transfer", 32'(fire), 1);
    compare("all high");
    // R2: enable off
    drive(0, '1, '1, '0, '1, '1, '0);
    chk("R2 disabled fire", 32'(fire), 0);
    chk("R2 disabled ready", 32'(sr), 0);
    compare("disabled");
    // R3: own valid irrelevant to own ready
    drive(1, 3'b110, '1, '0, '1, '1, '0);
    chk("R3 ready without own valid", 32'(sr[0]), 1);
    compare("src0 idle");
    // R4: own ready irrelevant to own valid
    drive(1, '1, '1, '0, 2'b10, '1, '0);
    chk("R4 valid without own ready", 32'(dv[0]), 1);
    compare("dst0 idle");
    // R5: one gate low stalls all
    drive(1, '1, 3'b101, '0, '1, '1, '0);
    chk("R5 gate low src_ready", 32'(sr), 0);
    chk("R5 gate low dst_valid", 32'(dv), 0);
    compare("gate low");
    // R7: same gate low but bypassed
    drive(1, '1, 3'b101, 3'b010, '1, '1, '0);
    chk("R7 bypassed gate", 32'(fire), 1);
    chk("R6 bypassed gets no ready", 32'(sr[1]), 0);
    compare("bypass gated");
    // R6: bypassed stream's own input toggled
    drive(1, 3'b101, '1, 3'b010, 2'b01, 2'b01, 2'b10);
    chk("R6 bypass valid low fire", 32'(fire), 1);
    chk("R6 bypass dst no valid", 32'(dv[1]), 0);
    compare("bypass toggle a");
    drive(1, 3'b111, '1, 3'b010, 2'b11, 2'b01, 2'b10);
    chk("R6 bypass valid high fire", 32'(fire), 1);
    chk("R6 outputs unchanged src", 32'(sr), 32'(3'b101));
    compare("bypass toggle b");
    // R9: all bypassed
    drive(1, '0, '0, '1, '0, '0, '1);
    chk("R9 all bypassed fire", 32'(fire), 1);
    chk("R9 all bypassed outputs", 32'({sr, dv}), 0);
    compare("all bypass");

    for (int n = 0; n < 3000; n++) begin
      logic [NS-1:0] v, g, b;
      logic [ND-1:0] r, gd, bd;
      for (int k = 0; k < NS; k++) begin
        v[k] = ($urandom % 5) != 0;
        g[k] = ($urandom % 6) != 0;
        b[k] = ($urandom % 4) == 0;
      end
      for (int k = 0; k < ND; k++) begin
        r[k]  = ($urandom % 5) != 0;
        gd[k] = ($urandom % 6) != 0;
        bd[k] = ($urandom % 4) == 0;
      end
      drive(($urandom % 8) != 0, v, g, b, r, gd, bd);
      compare("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule